// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers a wide set of level-sensitive interrupt lines into groups of eight and drives one output line per group toward a downstream interrupt controller. Input line `n` lands in group `n>>3` at bit `n&7`. Each group has an 8-bit enable mask. A group output is high whenever any enabled line of that group is pending. Pending bits follow the synchronised input level, so they are not latched.

Software controls the block over a small 32-bit register bus. The bus is addressed in words and has one-cycle read and write strobes. Registers come in four-word blocks. Block `k` covers groups `4k` to `4k+3`, and each group uses one byte lane. Within a block, one word sets enable bits, one word clears them, one word shows raw pending bits and one word shows masked pending bits. Addresses above the last group block show a two-word summary of which group outputs are active. An optional external mode silences every group at or above a configured limit.

Top module: `irq_group_combiner`

## Requirements
- R1: Line `n` of `irq_in` is pending bit `n&7` of group `n>>3`. A pending bit follows its input level through a two-flop synchroniser, so a level applied before clock edge e is first seen after edge e+1.
- R2: `grp_out[g]` is high exactly when the enable mask of group g ANDed with its pending bits is nonzero. It reflects mask and pending state with no further register.
- R3: Word address `{k,2'b00}` is the enable-set word. Writing it ORs byte lane j (bits `[8j+7:8j]`) into the mask of group `4k+j`.
- R4: Word address `{k,2'b01}` is the enable-clear word. Every 1 in byte lane j clears that mask bit of group `4k+j`. Mask bits written as 0 keep their value.
- R5: A read of word address `{k,2'b10}` returns the raw pending bits of groups `4k..4k+3`, with group `4k+j` in bits `[8j+7:8j]`.
- R6: A read of word address `{k,2'b11}` returns pending AND mask, packed the same way as R5.
- R7: When block index k is NUM_GROUPS/4 or higher, word 0 returns bit g set for every active output g below 32. Word 1 returns groups 32 to 63 in bits 0 to 31.
- R8: Reads of the set and clear words return the last value written to that word. After reset they read 0, except block 12 words 0 and 1 and block 13 words 0 and 1, which read 0x01010101.
- R9: Each of these is illegal: a write to words 2 or 3 of a block, a write anywhere in the summary region, and a read of summary words 2 or 3. An illegal access raises `bus_err` for exactly one cycle, after the access edge. It changes no mask, and an illegal read returns 0.
- R10: With EXT_MODE set, lines in groups at or above EXT_LIMIT are ignored. They read as 0 in the status words, and their group outputs stay low.
- R11: After reset every mask and pending bit is clear and every group output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Level-sensitive interrupt lines |
| bus_addr | input | AW | Word address: block index above, word select in bits [1:0] |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the read edge |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| grp_out | output | NUM_GROUPS | One output per group |

## Verification
Each result has a fixed latency. A level change on an input reaches the pending bits and the group output two clock edges later. A mask write changes the output right after its own edge. Read data and the error flag appear after the strobe's edge. The bench drives every stimulus on a falling edge and samples on the falling edge after the edge where the result is due. For the synchroniser it also samples one edge early, to confirm the output has not yet moved. A second, small instance runs in external mode to check that groups past the limit are ignored.

// File: rtl/irq_group_combiner.sv
module irq_group_combiner #(
  parameter int NUM_GROUPS = 64,
  parameter bit EXT_MODE   = 1'b0,
  parameter int EXT_LIMIT  = 64,
  localparam int NB = (NUM_GROUPS + 3) / 4,
  localparam int AW = $clog2(NB) + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*8-1:0] irq_in,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  output logic [NUM_GROUPS-1:0]   grp_out
);
  localparam int NG = NB * 4;
  localparam logic [AW-3:0] NB_L = (AW-2)'(NB);

  logic [NUM_GROUPS*8-1:0] sync1, sync2;
  logic [NG*8-1:0]  mask_q, pend;
  logic [NB*64-1:0] store_q;
  logic [NG-1:0]    act;
  logic [63:0]      summ;
  logic [31:0]      rd_val;
  logic [AW-3:0]    blk;
  logic [1:0]       word;
  logic             in_grp, wr_ok, illegal;

  assign blk     = bus_addr[AW-1:2];
  assign word    = bus_addr[1:0];
  assign in_grp  = blk < NB_L;
  assign wr_ok   = bus_wr && in_grp && !word[1];
  assign illegal = (bus_wr && !(in_grp && !word[1])) || (bus_rd && !in_grp && word[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
    end

  always_comb begin
    pend = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (!(EXT_MODE && g >= EXT_LIMIT)) pend[g*8 +: 8] = sync2[g*8 +: 8];
  end

  always_comb
    for (int g = 0; g < NG; g++) act[g] = |(mask_q[g*8 +: 8] & pend[g*8 +: 8]);

  always_comb begin
    summ = '0;
    summ[NUM_GROUPS-1:0] = act[NUM_GROUPS-1:0];
  end

  assign grp_out = act[NUM_GROUPS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else if (wr_ok) begin
      if (word[0]) mask_q[int'(blk)*32 +: 32] <= mask_q[int'(blk)*32 +: 32] & ~bus_wdata;
      else         mask_q[int'(blk)*32 +: 32] <= mask_q[int'(blk)*32 +: 32] | bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NB*2; i++)
        store_q[i*32 +: 32] <= (i >= 24 && i <= 27) ? 32'h0101_0101 : 32'h0;
    end else if (wr_ok)
      store_q[(int'(blk)*2 + int'(word[0]))*32 +: 32] <= bus_wdata;

  always_comb begin
    rd_val = '0;
    if (in_grp) begin
      case (word)
        2'd0, 2'd1: rd_val = store_q[(int'(blk)*2 + int'(word[0]))*32 +: 32];
        2'd2:       rd_val = pend[int'(blk)*32 +: 32];
        default:    rd_val = pend[int'(blk)*32 +: 32] & mask_q[int'(blk)*32 +: 32];
      endcase
    end else if (!word[1])
      rd_val = word[0] ? summ[63:32] : summ[31:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= illegal;
      if (bus_rd) bus_rdata <= illegal ? 32'h0 : rd_val;
    end

  // R2
  out_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (grp_out == '0));

  // R9
  illegal_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && illegal) |=> ($stable(mask_q) && bus_err));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_wr || bus_rd));

  for (genvar k = 0; k < NB; k++) begin : g_chk
    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !word[0] && int'(blk) == k) |=>
        ((mask_q[k*32 +: 32] & $past(bus_wdata)) == $past(bus_wdata)));
    // R4
    clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && word[0] && int'(blk) == k) |=>
        ((mask_q[k*32 +: 32] & $past(bus_wdata)) == 32'h0));
  end
endmodule

// File: tb/test_irq_group_combiner.sv
`timescale 1ns/1ps
module test_irq_group_combiner;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [511:0] irq;
  logic [6:0]  addr;
  logic        wr, rd, err;
  logic [31:0] wdata, rdata;
  logic [63:0] gout;

  logic [63:0] eirq;
  logic [3:0]  eaddr;
  logic        ewr, erd, eerr;
  logic [31:0] ewdata, erdata;
  logic [7:0]  egout;

  int total = 0, bad = 0;
  logic [7:0]  mm [64];
  logic [31:0] rv;
  logic        ev;

  irq_group_combiner i_irq_group_combiner (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err), .grp_out(gout));

  irq_group_combiner #(.NUM_GROUPS(8), .EXT_MODE(1'b1), .EXT_LIMIT(4)) i_irq_group_combiner_ext (
    .clk(clk), .rst_n(rst_n), .irq_in(eirq), .bus_addr(eaddr), .bus_wr(ewr),
    .bus_rd(erd), .bus_wdata(ewdata), .bus_rdata(erdata), .bus_err(eerr), .grp_out(egout));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] model_out();
    logic [63:0] o;
    for (int g = 0; g < 64; g++) o[g] = |(mm[g] & irq[g*8 +: 8]);
    return o;
  endfunction

  task automatic bwrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    ev = err;
    if (!a[6] && !a[1])
      for (int j = 0; j < 4; j++) begin
        if (a[0]) mm[int'(a[5:2])*4 + j] = mm[int'(a[5:2])*4 + j] & ~d[j*8 +: 8];
        else      mm[int'(a[5:2])*4 + j] = mm[int'(a[5:2])*4 + j] | d[j*8 +: 8];
      end
  endtask

  task automatic bread(input logic [6:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    rv = rdata; ev = err;
  endtask

  task automatic set_line(input int n, input logic v);
    @(negedge clk);
    irq[n] = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 outputs low", gout, 64'h0);
    bread(7'd64); chk("R7 summary lo at reset", rv, 0);
    bread(7'd0);  chk("R8 set word reset", rv, 0);
    bread(7'd48); chk("R8 block12 w0 reset", rv, 32'h0101_0101);
    bread(7'd49); chk("R8 block12 w1 reset", rv, 32'h0101_0101);
    bread(7'd53); chk("R8 block13 w1 reset", rv, 32'h0101_0101);
    bread(7'd56); chk("R8 block14 w0 reset", rv, 0);
  endtask

  task automatic t_enable();
    bwrite(7'd0, 32'h0000_00FF); chk("R9 legal write no err", ev, 0);
    set_line(3, 1'b1);
    chk("R3 group0 enabled", gout[0], 1);
    chk("R2 outputs match model", gout, model_out());
    bread(7'd2);  chk("R5 raw block0", rv, 32'h08);
    bread(7'd3);  chk("R6 masked block0", rv, 32'h08);
    bread(7'd64); chk("R7 summary lo", rv, 32'h1);
    bread(7'd0);  chk("R8 set word readback", rv, 32'hFF);
  endtask

  task automatic t_unmasked();
    set_line(33*8 + 1, 1'b1);
    chk("R2 unmasked stays low", gout[33], 0);
    bread(7'd34); chk("R5 raw block8 lane1", rv, 32'h0000_0200);
    bread(7'd35); chk("R6 masked block8 zero", rv, 0);
    bwrite(7'd32, 32'h0000_0200);
    chk("R3 group33 enabled", gout[33], 1);
    bread(7'd65); chk("R7 summary hi", rv, 32'h2);
  endtask

  task automatic t_clear();
    bwrite(7'd1, 32'h0000_0008);
    chk("R4 group0 cleared", gout[0], 0);
    bread(7'd3); chk("R4 masked after clear", rv, 0);
    bread(7'd1); chk("R8 clear word readback", rv, 32'h08);
    bread(7'd0); chk("R8 set word kept", rv, 32'hFF);
    bwrite(7'd33, 32'h0000_0100);
    chk("R4 zero bits untouched", gout[33], 1);
    chk("R2 outputs match model", gout, model_out());
  endtask

  task automatic t_illegal();
    bwrite(7'd2, 32'hFFFF_FFFF); chk("R9 write raw word", ev, 1);
    @(negedge clk); chk("R9 err one cycle", err, 0);
    bwrite(7'd35, 32'hFFFF_FFFF); chk("R9 write masked word", ev, 1);
    bread(7'd35); chk("R9 mask unchanged", rv, 32'h0000_0200);
    bwrite(7'd64, 32'hFFFF_FFFF); chk("R9 write summary", ev, 1);
    bread(7'd66); chk("R9 read summary w2 err", ev, 1);
    chk("R9 illegal read data", rv, 0);
    bread(7'd64); chk("R9 summary read legal", ev, 0);
    chk("R9 outputs unchanged", gout, model_out());
  endtask

  task automatic t_levels();
    bwrite(7'd0, 32'h8020_0000);
    @(negedge clk);
    irq[2*8 + 5] = 1'b1; irq[3*8 + 7] = 1'b1;
    @(negedge clk);
    chk("R1 not yet after one edge", gout[3:2], 2'b00);
    @(negedge clk);
    chk("R1 lines 21 and 31 map to groups 2,3", gout[3:2], 2'b11);
    bread(7'd2); chk("R5 raw lanes 2,3", rv, 32'h8020_0008);
    bread(7'd64); chk("R7 summary matches", rv, model_out() & 64'hFFFF_FFFF);
    set_line(3, 1'b0);
    bread(7'd2); chk("R1 pending follows low", rv, 32'h8020_0000);
    set_line(2*8 + 5, 1'b0);
    chk("R2 group2 low after drop", gout[2], 0);
    chk("R2 outputs match model", gout, model_out());
  endtask

  task automatic t_ext();
    @(negedge clk); eaddr = 4'd0; ewdata = 32'hFFFF_FFFF; ewr = 1'b1;
    @(negedge clk); eaddr = 4'd4;
    @(negedge clk); ewr = 1'b0;
    eirq[5*8] = 1'b1; eirq[2*8] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 ext outputs", egout, 8'b0000_0100);
    @(negedge clk); eaddr = 4'd6; erd = 1'b1;
    @(negedge clk); erd = 1'b0;
    chk("R10 ignored group raw", erdata, 0);
    @(negedge clk); eaddr = 4'd2; erd = 1'b1;
    @(negedge clk); erd = 1'b0;
    chk("R10 allowed group raw", erdata, 32'h0001_0000);
  endtask

  bit done = 0;
  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < 64; g++) mm[g] = '0;
    rst_n = 1'b0; irq = '0; addr = '0; wr = 0; rd = 0; wdata = '0;
    eirq = '0; eaddr = '0; ewr = 0; erd = 0; ewdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_unmasked();
    t_clear();
    t_illegal();
    t_levels();
    t_ext();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule